// File: doc/BRIEF.md
# Symmetric-Saturating Output Word Formatter

This block turns a wide signed sample into a 16-bit output word. Samples that fall outside the 16-bit range are clipped. The clip is symmetric, so the two extremes have equal magnitude. As a result, the single code that has no positive partner (0x8000 in two's complement, 0x0000 in offset binary) is never produced. A one-bit format input picks the coding of each sample.

The format input is taken together with each valid sample, so a change of format applies from the next valid sample onward. The block has a single register stage. The valid strobe goes through the same stage, so the output word and its valid flag leave together one clock after the sample enters. While no sample arrives, the output word keeps its last value.

Top module: `ssf_top`

## Requirements
- R1: While rst_n is low, and on the first clock after it goes low, out_valid is 0 and out_word is 16'h0000.
- R2: out_valid equals the in_valid value from exactly one clock earlier. A sample accepted at edge k appears on out_word after edge k.
- R3: With fmt_sel = 0 (two's complement), a sample in the range -32767 to +32767 appears as its low 16 bits, unchanged.
- R4: With fmt_sel = 0, any sample above +32767 gives 16'h7FFF.
- R5: With fmt_sel = 0, any sample below -32767 gives 16'h8001. This includes exactly -32768.
- R6: With fmt_sel = 1 (offset binary), the output is the clipped two's complement word with bit 15 inverted. Output codes therefore run from 16'h0001 to 16'hFFFF, and zero maps to 16'h8000.
- R7: A valid output word is never 16'h8000 when fmt_sel was 0 for that sample. It is never 16'h0000 when fmt_sel was 1.
- R8: A clock on which in_valid is low leaves out_word unchanged and makes out_valid 0.
- R9: fmt_sel is sampled only together with a valid sample. Changing it while in_valid is low does not alter the held word. The next valid sample uses the new format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 20 | Signed input sample (IN_W) |
| fmt_sel | input | 1 | 0 = two's complement, 1 = offset binary |
| out_valid | output | 1 | Output word strobe |
| out_word | output | 16 | Formatted, clipped word (OUT_W) |

## Verification
The assertions assume that in_valid is low during reset. They also assume that in_sample and fmt_sel are defined whenever in_valid is high. The clip checks read the previous in_sample as a signed value. Every property is guarded by the reset level of the prior cycle, so no check looks into a reset cycle.

The bench keeps to these assumptions by holding in_valid low until after reset. It drives all inputs on the falling edge, sets every field of a sample in the same cycle, and covers both range limits, the unpaired minimum, and format switches made while idle.

// File: rtl/ssf_pkg.sv
// Shared types for the symmetric-saturating formatter.
// Assumes: one select bit, 0 meaning two's complement.
package ssf_pkg;
    typedef enum logic {
        FMT_TWOS   = 1'b0,
        FMT_OFFSET = 1'b1
    } fmt_e;
endpackage

// File: rtl/ssf_clip.sv
// Symmetric clipper: limits a signed IN_W sample to +/-(2^(OUT_W-1)-1).
// Assumes IN_W >= OUT_W >= 2. Purely combinational.
module ssf_clip #(
    parameter int IN_W  = 20,
    parameter int OUT_W = 16
) (
    input  logic signed [IN_W-1:0] sample_i,
    output logic [OUT_W-1:0]       word_o
);
    localparam logic [OUT_W-1:0] TOP_CODE = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] BOT_CODE = {1'b1, {(OUT_W-2){1'b0}}, 1'b1};
    localparam logic [OUT_W-1:0] BAD_CODE = {1'b1, {(OUT_W-1){1'b0}}};

    generate
        if (IN_W > OUT_W) begin : g_wide
            localparam logic signed [IN_W-1:0] POS_LIM =
                {{(IN_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
            localparam logic signed [IN_W-1:0] NEG_LIM = -POS_LIM;
            // Purpose: compare against both limits and pick the clipped word.
            always_comb begin
                if (sample_i > POS_LIM)
                    word_o = TOP_CODE;
                else if (sample_i < NEG_LIM)
                    word_o = BOT_CODE;
                else
                    word_o = sample_i[OUT_W-1:0];
            end
        end else begin : g_same
            // Purpose: only the unpaired minimum code needs replacing.
            always_comb begin
                if (sample_i[OUT_W-1:0] == BAD_CODE)
                    word_o = BOT_CODE;
                else
                    word_o = sample_i[OUT_W-1:0];
            end
        end
    endgenerate
endmodule

// File: rtl/ssf_encode.sv
// Format encoder: passes the clipped word through, or flips its sign bit
// for offset binary. Assumes the input is already clipped symmetrically.
module ssf_encode
    import ssf_pkg::*;
#(
    parameter int OUT_W = 16
) (
    input  logic [OUT_W-1:0] word_i,
    input  fmt_e             fmt_i,
    output logic [OUT_W-1:0] word_o
);
    // Purpose: toggle the MSB when offset binary is selected.
    always_comb begin
        word_o = {word_i[OUT_W-1] ^ (fmt_i == FMT_OFFSET), word_i[OUT_W-2:0]};
    end
endmodule

// File: rtl/ssf_stage.sv
// Output register: loads the word on valid, holds it otherwise, and delays
// valid by one clock. Synchronous active-low reset clears both.
module ssf_stage #(
    parameter int OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [OUT_W-1:0] word_i,
    output logic             valid_o,
    output logic [OUT_W-1:0] word_o
);
    // Purpose: register the formatted word and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            word_o  <= '0;
        end else begin
            valid_o <= load_i;
            if (load_i)
                word_o <= word_i;
        end
    end
endmodule

// File: rtl/ssf_top.sv
// Top of the symmetric-saturating formatter: clip, encode, register.
// Assumes fmt_sel and in_sample are meaningful whenever in_valid is high.
module ssf_top
    import ssf_pkg::*;
#(
    parameter int IN_W  = 20,
    parameter int OUT_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic signed [IN_W-1:0] in_sample,
    input  logic                   fmt_sel,
    output logic                   out_valid,
    output logic [OUT_W-1:0]       out_word
);
    logic [OUT_W-1:0] clip_w;
    logic [OUT_W-1:0] enc_w;
    fmt_e             fmt_w;

    // Purpose: map the select pin onto the format type.
    always_comb fmt_w = fmt_e'(fmt_sel);

    ssf_clip #(.IN_W(IN_W), .OUT_W(OUT_W)) u_clip (
        .sample_i (in_sample),
        .word_o   (clip_w)
    );

    ssf_encode #(.OUT_W(OUT_W)) u_enc (
        .word_i (clip_w),
        .fmt_i  (fmt_w),
        .word_o (enc_w)
    );

    ssf_stage #(.OUT_W(OUT_W)) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (in_valid),
        .word_i  (enc_w),
        .valid_o (out_valid),
        .word_o  (out_word)
    );
endmodule

// File: rtl/ssf_checker.sv
// Property checker for ssf_top, attached by bind below.
module ssf_checker #(
    parameter int IN_W  = 20,
    parameter int OUT_W = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic signed [IN_W-1:0] in_sample,
    input logic                   fmt_sel,
    input logic                   out_valid,
    input logic [OUT_W-1:0]       out_word
);
    localparam logic signed [IN_W:0] POS_LIM = (IN_W+1)'(2**(OUT_W-1) - 1);
    localparam logic signed [IN_W:0] NEG_LIM = -POS_LIM;
    localparam logic [OUT_W-1:0] TOP_CODE = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic [OUT_W-1:0] BOT_CODE = {1'b1, {(OUT_W-2){1'b0}}, 1'b1};
    localparam logic [OUT_W-1:0] BAD_TWOS = {1'b1, {(OUT_W-1){1'b0}}};

    logic signed [IN_W:0] s_ext;
    always_comb s_ext = (IN_W+1)'(in_sample);

    // R1: reset clears the output register
    assert_reset_clear_R1: assert property (@(posedge clk)
        !$past(rst_n) |-> (!out_valid && out_word == '0));

    // R2: valid delayed by exactly one clock
    assert_valid_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    // R4: positive overflow clips to the top code in two's complement
    assert_pos_clip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && !$past(fmt_sel) && $past(s_ext) > POS_LIM)
        |-> (out_word == TOP_CODE));

    // R5: negative overflow clips to the symmetric bottom code
    assert_neg_clip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && !$past(fmt_sel) && $past(s_ext) < NEG_LIM)
        |-> (out_word == BOT_CODE));

    // R7: the unpaired code never appears on a valid word
    assert_no_unpaired_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && out_valid)
        |-> (out_word != ($past(fmt_sel) ? '0 : BAD_TWOS)));

    // R8: idle clocks hold the word
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |-> ($stable(out_word) && !out_valid));
endmodule

bind ssf_top ssf_checker #(.IN_W(IN_W), .OUT_W(OUT_W)) u_ssf_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .fmt_sel   (fmt_sel),
    .out_valid (out_valid),
    .out_word  (out_word)
);

// File: tb/tb_ssf_top.sv
module tb_ssf_top;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [19:0] in_sample = '0;
    logic               fmt_sel = 1'b0;
    logic               out_valid;
    logic [15:0]        out_word;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ssf_top dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .fmt_sel(fmt_sel), .out_valid(out_valid), .out_word(out_word)
    );

    function automatic logic [15:0] model(input int s, input logic f);
        logic [15:0] c;
        if (s > 32767) c = 16'h7FFF;
        else if (s < -32767) c = 16'h8001;
        else c = 16'(s);
        if (f) c[15] = ~c[15];
        return c;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One sample, then check word and valid one clock later.
    task automatic send(input string req, input int s, input logic f);
        @(negedge clk);
        in_valid = 1'b1; in_sample = 20'(s); fmt_sel = f;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, out_word, model(s, f));
        check({req, " R2 valid"}, {15'd0, out_valid}, 16'd1);
    endtask

    task automatic t_reset();
        @(negedge clk); @(negedge clk);
        check("R1 valid", {15'd0, out_valid}, 16'd0);
        check("R1 word", out_word, 16'h0000);
        rst_n = 1'b1;
    endtask

    task automatic t_twos();
        send("R3 zero", 0, 1'b0);
        send("R3 pos", 1234, 1'b0);
        send("R3 neg", -1234, 1'b0);
        send("R3 top", 32767, 1'b0);
        send("R3 bottom", -32767, 1'b0);
    endtask

    task automatic t_clip();
        send("R4 just over", 32768, 1'b0);
        send("R4 max", 524287, 1'b0);
        send("R5 R7 minus32768", -32768, 1'b0);
        send("R5 under", -40000, 1'b0);
        send("R5 min", -524288, 1'b0);
    endtask

    task automatic t_offset();
        send("R6 zero", 0, 1'b1);
        send("R6 top", 32767, 1'b1);
        send("R6 R7 minus32768", -32768, 1'b1);
        send("R6 minus1", -1, 1'b1);
        send("R6 over", 100000, 1'b1);
    endtask

    task automatic t_hold();
        send("R8 load", 555, 1'b0);
        in_sample = 20'sd7;
        repeat (3) @(negedge clk);
        check("R8 held word", out_word, model(555, 1'b0));
        check("R8 valid low", {15'd0, out_valid}, 16'd0);
    endtask

    task automatic t_fmt_live();
        send("R9 first", -200, 1'b0);
        fmt_sel = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R9 idle switch", out_word, model(-200, 1'b0));
        send("R9 next", -200, 1'b1);
    endtask

    task automatic t_stream();
        int vals[4] = '{10, 40000, -50000, -5};
        logic fm[4] = '{1'b0, 1'b1, 1'b0, 1'b1};
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (i > 0) begin
                check("R2 stream", out_word, model(vals[i-1], fm[i-1]));
                check("R2 stream valid", {15'd0, out_valid}, 16'd1);
            end
            in_valid = 1'b1; in_sample = 20'(vals[i]); fmt_sel = fm[i];
        end
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 stream last", out_word, model(vals[3], fm[3]));
        @(negedge clk);
        check("R2 valid drop", {15'd0, out_valid}, 16'd0);
    endtask

    initial begin
        t_reset();
        t_twos();
        t_clip();
        t_offset();
        t_hold();
        t_fmt_live();
        t_stream();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule